// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block merges fourteen internal interrupt sources into a single maskable interrupt request for an 8-bit CPU. It also forms the vector byte that the CPU fetches during the interrupt acknowledge when it runs in its vectored mode. The sources are a raster line interrupt, receive and transmit events from two UARTs, eight timer channels and the video frame interrupt. Each source signals with a one-cycle strobe, and the block holds the event in a pending flag until it is serviced. An expansion bus can also request service, and it ranks below every internal source. It may place its own vector on the bus or leave the bus undriven.

A control byte supplies the three high bits of the vector and selects the mode. In vectored mode the block asserts the request while anything is outstanding. On the rising edge of the acknowledge strobe it chooses the most urgent source and freezes the vector for as long as the acknowledge stays high. In pulse mode it drives no vector. Each serviced event instead produces a request pulse of fixed length.

The controller is a four-state machine. IDLE waits for work. VEC_ACK holds the frozen vector. PULSE drives the timed request. GAP forces the request low between pulses. Its transitions are:
- IDLE to VEC_ACK when the acknowledge rises in vectored mode.
- VEC_ACK to IDLE when the acknowledge falls.
- IDLE to PULSE in pulse mode when any request is present.
- PULSE to GAP on the last pulse cycle.
- GAP to IDLE after one cycle.

Top module: `irq_vector_gen`

## Requirements
- R1: For an internal winner, the vector is {ctrl[7:5], code[3:0], 1'b0}, with the code in bits 4:1 and bit 0 always 0.
- R2: The source on request bit i has code i, and the lowest code wins. Bit 0 is the line interrupt, bit 1 UART0 receive, bit 2 UART1 receive, bits 3 to 10 timer channels 0 to 7, bit 11 the frame interrupt, bit 12 UART0 transmit and bit 13 UART1 transmit.
- R3: When no internal flag is pending at the acknowledge, the vector comes from the expansion bus if it requests and marks its vector valid. In every other such case the vector is 0xFF, including an acknowledge with no requester at all.
- R4: The vector is captured at the rising edge of the acknowledge. It is then held unchanged, with the valid output high, until the acknowledge falls, whatever the control byte or the requests do meanwhile. Outside the acknowledge, the valid output is 0 and the vector output reads 0x00.
- R5: A strobe sets its pending flag, which holds until that source wins an acknowledge. Only the winner is cleared, so lower-priority flags stay pending. A new strobe that arrives in the same cycle as its flag is cleared leaves the flag set.
- R6: In vectored mode the request is high in IDLE whenever a flag is pending or the expansion bus requests, and it is low while an acknowledge is held.
- R7: In pulse mode (ctrl[0]=0), each pending event or expansion request produces a request pulse exactly PULSE_LEN cycles long, followed by at least one low cycle. Each pulse consumes the most urgent pending flag. The valid output stays 0 and the acknowledge has no effect.
- R8: The reserved control bits 4 and 2:1, and bit 3, have no effect on the vector.
- R9: After reset no flag is pending, the request and valid outputs are 0, and the vector output is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctrl_i | input | 8 | Control byte: bits 7:5 vector high bits, bit 0 mode (1 = vectored) |
| src_req_i | input | NUM_SRC | One-cycle event strobes, bit index = priority code |
| exp_req_i | input | 1 | Expansion bus request (level) |
| exp_vec_valid_i | input | 1 | Expansion bus is supplying a vector |
| exp_vec_i | input | 8 | Vector supplied by the expansion bus |
| ack_i | input | 1 | Interrupt acknowledge, high for the acknowledge cycle |
| irq_o | output | 1 | Interrupt request to the CPU |
| vec_valid_o | output | 1 | Vector is being driven |
| vector_o | output | 8 | Vector byte |

## Verification
The first patterns use a single strobe, and then three strobes that arrive together and are acknowledged one by one. Together they separate a correct priority encoder from one that picks the highest index or that clears more than the winner. A held acknowledge, during which the control byte changes and a new strobe arrives, shows whether the vector is truly latched. A strobe that lands in the same cycle as its own acknowledge shows whether the flag is set or cleared when both happen at once. Expansion requests are tried with and without a supplied vector, alongside an internal request, and as a bare acknowledge. In pulse mode, two queued events are counted as pulse lengths and as a number of pulses while the acknowledge toggles.

// File: rtl/irqv_pkg.sv
package irqv_pkg;
    localparam int VEC_W   = 8;
    localparam int CODE_W  = 4;
    localparam int HI_W    = VEC_W - 1 - CODE_W;
    localparam int MAX_SRC = 1 << CODE_W;
    localparam int MODE_BIT = 0;
    localparam logic [VEC_W-1:0] FLOAT_VEC = 8'hFF;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_VEC_ACK = 2'd1,
        ST_PULSE   = 2'd2,
        ST_GAP     = 2'd3
    } irqv_state_e;

    function automatic logic [VEC_W-1:0] compose_vec(
        input logic [HI_W-1:0]   hi,
        input logic [CODE_W-1:0] code
    );
        return {hi, code, 1'b0};
    endfunction
endpackage

// File: rtl/irqv_pending.sv
module irqv_pending #(
    parameter int N = 14
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] pend_o
);
    generate
        for (genvar g = 0; g < N; g++) begin : g_flag
            logic flag_q;
            always_ff @(posedge clk_i or negedge rst_ni) begin
                if (!rst_ni) begin
                    flag_q <= 1'b0;
                end else if (set_i[g]) begin
                    flag_q <= 1'b1;
                end else if (clr_i[g]) begin
                    flag_q <= 1'b0;
                end
            end
            assign pend_o[g] = flag_q;
        end
    endgenerate

    // R5: at most one flag is cleared per acknowledge
    assert_clr_onehot_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0(clr_i));

    // R5: a clear without a coincident set empties the flag
    assert_clear_takes_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((clr_i & ~set_i) != '0) |=> ((pend_o & $past(clr_i & ~set_i)) == '0));

    // R5: a strobe always leaves its flag pending
    assert_set_holds_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (set_i != '0) |=> ((pend_o & $past(set_i)) == $past(set_i)));
endmodule

// File: rtl/irqv_prio_enc.sv
module irqv_prio_enc #(
    parameter int N  = 14,
    parameter int CW = 4
) (
    input  logic [N-1:0]  req_i,
    output logic          found_o,
    output logic [CW-1:0] code_o,
    output logic [N-1:0]  onehot_o
);
    always_comb begin
        found_o  = 1'b0;
        code_o   = '0;
        onehot_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req_i[i]) begin
                found_o     = 1'b1;
                code_o      = CW'(i);
                onehot_o    = '0;
                onehot_o[i] = 1'b1;
            end
        end
    end
endmodule

// File: rtl/irqv_pulse_timer.sv
module irqv_pulse_timer #(
    parameter int LEN = 32
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic load_i,
    input  logic run_i,
    output logic last_o
);
    localparam int CW = (LEN > 1) ? $clog2(LEN) : 1;
    localparam logic [CW-1:0] LAST = CW'(LEN - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= '0;
        end else if (run_i && (cnt_q != LAST)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign last_o = (cnt_q == LAST);

    // R7: the pulse counter never passes the programmed length
    assert_cnt_bound_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cnt_q <= LAST);
endmodule

// File: rtl/irq_vector_gen.sv
module irq_vector_gen #(
    parameter int NUM_SRC   = 14,
    parameter int PULSE_LEN = 32
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [7:0]         ctrl_i,
    input  logic [NUM_SRC-1:0] src_req_i,
    input  logic               exp_req_i,
    input  logic               exp_vec_valid_i,
    input  logic [7:0]         exp_vec_i,
    input  logic               ack_i,
    output logic               irq_o,
    output logic               vec_valid_o,
    output logic [7:0]         vector_o
);
    import irqv_pkg::*;

    localparam int HI_LSB = VEC_W - HI_W;

    irqv_state_e          state_q, state_d;
    logic                 ack_q;
    logic                 ack_rise;
    logic                 vect_mode;
    logic [NUM_SRC-1:0]   pend;
    logic [NUM_SRC-1:0]   win_onehot;
    logic [NUM_SRC-1:0]   clr;
    logic                 found;
    logic [CODE_W-1:0]    win_code;
    logic                 any_req;
    logic                 take_vec;
    logic                 start_pulse;
    logic                 pulse_last;
    logic [VEC_W-1:0]     vec_q;
    logic                 lat_internal_q;

    irqv_pending #(.N(NUM_SRC)) u_pending (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .set_i  (src_req_i),
        .clr_i  (clr),
        .pend_o (pend)
    );

    irqv_prio_enc #(.N(NUM_SRC), .CW(CODE_W)) u_enc (
        .req_i    (pend),
        .found_o  (found),
        .code_o   (win_code),
        .onehot_o (win_onehot)
    );

    irqv_pulse_timer #(.LEN(PULSE_LEN)) u_timer (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .load_i (start_pulse),
        .run_i  (state_q == ST_PULSE),
        .last_o (pulse_last)
    );

    assign ack_rise    = ack_i & ~ack_q;
    assign vect_mode   = ctrl_i[MODE_BIT];
    assign any_req     = found | exp_req_i;
    assign take_vec    = (state_q == ST_IDLE) && vect_mode && ack_rise;
    assign start_pulse = (state_q == ST_IDLE) && !vect_mode && any_req;
    assign clr         = ((take_vec || start_pulse) && found) ? win_onehot : '0;

    // state register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (take_vec) begin
                    state_d = ST_VEC_ACK;
                end else if (start_pulse) begin
                    state_d = ST_PULSE;
                end
            end
            ST_VEC_ACK: begin
                if (!ack_i) begin
                    state_d = ST_IDLE;
                end
            end
            ST_PULSE: begin
                if (pulse_last) begin
                    state_d = ST_GAP;
                end
            end
            ST_GAP: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    // acknowledge edge detector and vector latch
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            ack_q          <= 1'b0;
            vec_q          <= '0;
            lat_internal_q <= 1'b0;
        end else begin
            ack_q <= ack_i;
            if (take_vec) begin
                lat_internal_q <= found;
                if (found) begin
                    vec_q <= compose_vec(ctrl_i[VEC_W-1:HI_LSB], win_code);
                end else if (exp_req_i && exp_vec_valid_i) begin
                    vec_q <= exp_vec_i;
                end else begin
                    vec_q <= FLOAT_VEC;
                end
            end
        end
    end

    // outputs
    always_comb begin
        irq_o       = 1'b0;
        vec_valid_o = 1'b0;
        vector_o    = '0;
        unique case (state_q)
            ST_IDLE:    irq_o = vect_mode && any_req;
            ST_VEC_ACK: begin
                vec_valid_o = 1'b1;
                vector_o    = vec_q;
            end
            ST_PULSE:   irq_o = 1'b1;
            ST_GAP:     irq_o = 1'b0;
        endcase
    end

    // R4: a held acknowledge keeps the vector frozen and driven
    assert_vec_stable_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (vec_valid_o && ack_i) |=> (vec_valid_o && $stable(vector_o)));

    // R1: an internally sourced vector has bit 0 clear
    assert_vec_lsb_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (vec_valid_o && lat_internal_q) |-> (vector_o[0] == 1'b0));

    // R7: a vector is only driven after an acknowledge in vectored mode
    assert_vec_needs_mode_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(vec_valid_o) |-> ($past(ack_i) && $past(ctrl_i[MODE_BIT])));
endmodule

// File: tb/irq_vector_gen_tb.sv
`timescale 1ns/1ps
module irq_vector_gen_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NSRC  = 14;
    localparam int PULSE = 6;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [7:0]      ctrl = 8'hA9;
    logic [NSRC-1:0] src = '0;
    logic            exp_req = 1'b0;
    logic            exp_valid = 1'b0;
    logic [7:0]      exp_vec = 8'h00;
    logic            ack = 1'b0;
    logic            irq;
    logic            vvalid;
    logic [7:0]      vector;

    int n_cmp = 0;
    int n_bad = 0;
    bit chk_on = 1'b0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_vector_gen #(.NUM_SRC(NSRC), .PULSE_LEN(PULSE)) dut_i (
        .clk_i           (clk),
        .rst_ni          (rst_n),
        .ctrl_i          (ctrl),
        .src_req_i       (src),
        .exp_req_i       (exp_req),
        .exp_vec_valid_i (exp_valid),
        .exp_vec_i       (exp_vec),
        .ack_i           (ack),
        .irq_o           (irq),
        .vec_valid_o     (vvalid),
        .vector_o        (vector)
    );

    task automatic check(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
        end
    endtask

    // behavioural reference: 0 idle, 1 holding vector, 2 pulsing, 3 gap
    int         m_pend[NSRC];
    int         m_mode_st;
    int         m_cnt;
    logic [7:0] m_vec;
    logic       m_ackq;

    always @(posedge clk) begin : model
        int  w;
        bit  rise;
        bit  anyq;
        if (!rst_n) begin
            foreach (m_pend[i]) m_pend[i] = 0;
            m_mode_st = 0; m_cnt = 0; m_vec = 8'h00; m_ackq = 1'b0;
        end else begin
            w = -1;
            for (int i = NSRC - 1; i >= 0; i--) if (m_pend[i] != 0) w = i;
            rise = ack && !m_ackq;
            anyq = (w >= 0) || exp_req;
            case (m_mode_st)
                0: if (ctrl[0] && rise) begin
                       m_mode_st = 1;
                       if (w >= 0) m_vec = {ctrl[7:5], 5'b0} | 8'(w * 2);
                       else if (exp_req && exp_valid) m_vec = exp_vec;
                       else m_vec = 8'hFF;
                   end else if (!ctrl[0] && anyq) begin
                       m_mode_st = 2; m_cnt = 1;
                   end else w = -1;
                1: begin if (!ack) m_mode_st = 0; w = -1; end
                2: begin if (m_cnt == PULSE) m_mode_st = 3; else m_cnt++; w = -1; end
                default: begin m_mode_st = 0; w = -1; end
            endcase
            for (int i = 0; i < NSRC; i++) begin
                if (src[i]) m_pend[i] = 1;
                else if (i == w) m_pend[i] = 0;
            end
            m_ackq = ack;
        end
    end

    always @(negedge clk) begin
        if (chk_on && !done) begin
            bit any_p;
            any_p = 1'b0;
            foreach (m_pend[i]) if (m_pend[i] != 0) any_p = 1'b1;
            check("model R6 irq", irq,
                  ((m_mode_st == 0 && ctrl[0] && (any_p || exp_req)) || m_mode_st == 2) ? 1 : 0);
            check("model R4 valid", vvalid, (m_mode_st == 1) ? 1 : 0);
            check("model R1 vector", vector, (m_mode_st == 1) ? m_vec : 0);
        end
    end

    task automatic cyc();
        @(posedge clk); #1;
    endtask

    task automatic strobe(input logic [NSRC-1:0] m);
        cyc(); src = m;
        cyc(); src = '0;
    endtask

    task automatic ack_cycle(output logic [7:0] v, output logic vv);
        cyc(); ack = 1'b1;
        cyc();
        @(negedge clk); v = vector; vv = vvalid;
        cyc(); ack = 1'b0;
        cyc();
        @(negedge clk);
    endtask

    initial begin : stim
        logic [7:0] v, v2;
        logic vv, vv2;
        int highs, runs;
        bit prev;

        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check("R9 irq after reset", irq, 0);
        check("R9 valid after reset", vvalid, 0);
        check("R9 vector after reset", vector, 0);
        chk_on = 1'b1;

        // single source, timer channel 2 = code 5
        strobe(NSRC'(1) << 5);
        @(negedge clk);
        check("R6 irq with pending", irq, 1);
        ack_cycle(v, vv);
        check("R1 vector code5", v, 8'hAA);
        check("R4 valid during ack", vv, 1);
        check("R6 irq idle after service", irq, 0);

        // three together: codes 1, 11, 13
        strobe((NSRC'(1) << 1) | (NSRC'(1) << 11) | (NSRC'(1) << 13));
        ack_cycle(v, vv);
        check("R2 first winner code1", v, 8'hA2);
        check("R5 lower still pending", irq, 1);
        ack_cycle(v, vv);
        check("R2 second winner code11", v, 8'hB6);
        ack_cycle(v, vv);
        check("R2 last winner code13", v, 8'hBA);
        check("R5 all serviced", irq, 0);

        // held acknowledge, control and requests change underneath (code 9)
        strobe(NSRC'(1) << 9);
        cyc(); ack = 1'b1;
        cyc();
        @(negedge clk); v = vector; vv = vvalid;
        check("R6 irq low during ack", irq, 0);
        ctrl = 8'h69; src = NSRC'(1);
        cyc(); src = '0;
        cyc();
        @(negedge clk); v2 = vector; vv2 = vvalid;
        check("R4 vector latched", v, 8'hB2);
        check("R4 vector stable", v2, 8'hB2);
        check("R4 still valid", vv2, 1);
        cyc(); ack = 1'b0;
        cyc();
        @(negedge clk);
        check("R4 valid low after ack", vvalid, 0);
        check("R4 vector zero after ack", vector, 0);
        check("R5 new strobe pending", irq, 1);
        ack_cycle(v, vv);
        check("R1 new high bits code0", v, 8'h60);
        ctrl = 8'hA9;

        // strobe coincides with its own clear (code 4)
        strobe(NSRC'(1) << 4);
        cyc(); ack = 1'b1; src = NSRC'(1) << 4;
        cyc(); src = '0;
        @(negedge clk);
        check("R5 vector code4", vector, 8'hA8);
        cyc(); ack = 1'b0;
        cyc();
        @(negedge clk);
        check("R5 set wins over clear", irq, 1);
        ack_cycle(v, vv);
        check("R5 second service code4", v, 8'hA8);
        check("R5 drained", irq, 0);

        // expansion bus
        cyc(); exp_req = 1'b1; exp_valid = 1'b1; exp_vec = 8'h3C;
        @(negedge clk);
        check("R6 irq from expansion", irq, 1);
        ack_cycle(v, vv);
        check("R3 supplied vector", v, 8'h3C);
        cyc(); exp_valid = 1'b0;
        ack_cycle(v, vv);
        check("R3 no vector supplied", v, 8'hFF);
        strobe(NSRC'(1) << 12);
        cyc(); exp_valid = 1'b1;
        ack_cycle(v, vv);
        check("R3 internal beats expansion", v, 8'hB8);
        check("R3 expansion still requesting", irq, 1);
        cyc(); exp_req = 1'b0; exp_valid = 1'b0;
        ack_cycle(v, vv);
        check("R3 bare acknowledge", v, 8'hFF);

        // reserved and unrelated control bits
        cyc(); ctrl = 8'hBF;
        strobe(NSRC'(1) << 7);
        ack_cycle(v, vv);
        check("R8 reserved bits set", v, 8'hAE);
        cyc(); ctrl = 8'hA9;
        strobe(NSRC'(1) << 7);
        ack_cycle(v, vv);
        check("R8 reserved bits clear", v, 8'hAE);

        // pulse mode: two queued events, acknowledge toggling
        cyc(); ctrl = 8'hA8;
        strobe((NSRC'(1) << 2) | (NSRC'(1) << 8));
        highs = 0; runs = 0; prev = 1'b0;
        for (int i = 0; i < 2 * PULSE + 12; i++) begin
            @(negedge clk);
            if (vvalid) check("R7 no vector in pulse mode", vvalid, 0);
            if (irq) highs++;
            if (irq && !prev) runs++;
            prev = irq;
            cyc(); ack = ~ack;
        end
        check("R7 total pulse cycles", highs, 2 * PULSE);
        check("R7 pulse count", runs, 2);
        check("R7 flags consumed", irq, 0);
        cyc(); ack = 1'b0; ctrl = 8'hA9;
        cyc();
        @(negedge clk);
        check("R7 nothing left for vectored mode", irq, 0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule